// File: doc/BRIEF.md
# Per-Line Modem Signal Tracker with Automatic Hang-Up

This block keeps the modem-side view of eight serial lines for a terminal multiplexer. Software owns a 16-bit transmission control word. Its low byte holds one transmit-enable bit per line. Its high byte holds one data-terminal-ready bit per line: bit 8+i belongs to line i. The block reports a read-only 16-bit modem status word. Its low byte holds one ring-indicator bit per line, with bit i for line i. Its high byte holds one carrier-detect bit per line, with bit 8+i for line i.

Each line has its own small state machine. The states are LN_IDLE (no ring, no carrier), LN_RING (ring only), LN_CARR (carrier only) and LN_BOTH (ring and carrier). A connect request moves a line to carrier when its ready bit is set (the carrier-on-connect transition). Otherwise the line moves to ring (the ring-on-connect transition). A control-word write that sets the ready bit of a ringing line turns the ring into carrier (the answer transition). A line that is not connected loses its carrier (the drop transition). When automatic disconnect is enabled, a write that clears the ready bit of a connected line loses the carrier and raises a one-cycle hang-up pulse for that line (the hang-up transition). The line's connected input is then expected to fall.

A status-clear pulse wipes the transmit enables and keeps the ready bits. A full reset clears everything.

Top module: `modem_ctl`

## Requirements
- R1: After reset, tcr_q, msr_q and hangup are all zero.
- R2: A write with tcr_we high and csr_clr low loads tcr_wdata[7:0] into the low byte when tcr_be[0] is 1, and loads tcr_wdata[15:8] into the high byte when tcr_be[1] is 1. The new value appears on tcr_q one cycle later.
- R3: A csr_clr pulse zeroes tcr_q[7:0] and keeps tcr_q[15:8]. A write in the same cycle is discarded, including its modem effects.
- R4: msr_q[7:0] are the ring bits and msr_q[15:8] the carrier bits, with bit i and bit 8+i belonging to line i. They are updated one cycle after the causing inputs.
- R5: A connect request on line i sets carrier bit 8+i when the line's ready bit is 1. Otherwise it sets ring bit i. The ready bit used is the value after any write in the same cycle.
- R6: On every accepted write, the carrier of each line is set where the new ready bit and the current ring bit are both 1. Then the ring bit of each line is cleared where the new ready bit is 1.
- R7: With auto_en high, an accepted write that changes a connected line's ready bit from 1 to 0 clears that line's carrier and drives hangup[i] high for exactly the next cycle.
- R8: With mctl_en high, the carrier bit of every line whose connected input is low is cleared. This rule is applied after the write and connect rules of the same cycle.
- R9: With mctl_en low, msr_q does not change and hangup stays zero, whatever the other inputs do. Control-word writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous full reset |
| mctl_en | input | 1 | Modem control enable |
| auto_en | input | 1 | Automatic disconnect enable |
| csr_clr | input | 1 | Status-clear pulse (clears transmit enables only) |
| tcr_we | input | 1 | Control-word write strobe |
| tcr_be | input | 2 | Byte enables for the control-word write |
| tcr_wdata | input | 16 | Control-word write data |
| conn_req | input | 8 | Per-line new-connection pulses |
| connected | input | 8 | Per-line connected levels |
| tcr_q | output | 16 | Control word (ready bits in the high byte) |
| msr_q | output | 16 | Modem status (ring bits in the low byte, carrier bits in the high byte) |
| hangup | output | 8 | Per-line one-cycle hang-up pulses |

## Verification
A line machine stuck in a wrong state shows up on the very next cycle as a wrong ring or carrier bit in msr_q. The bench compares msr_q on every cycle, so the fault is caught at once. A wrong old-versus-new ready comparison shows up as a missing or extra pulse on hangup one cycle after the write. A wrong order of the write, connect and disconnect rules within one cycle only shows when they coincide, so the stimulus makes them coincide often under all four enable combinations. A corrupted control-word byte appears on tcr_q one cycle after the write or clear.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;

    // Per-line modem condition: {carrier, ring}
    typedef enum logic [1:0] {
        LN_IDLE = 2'b00,
        LN_RING = 2'b01,
        LN_CARR = 2'b10,
        LN_BOTH = 2'b11
    } line_state_t;

    function automatic line_state_t pack_state(input logic ring, input logic carr);
        line_state_t s;
        unique case ({carr, ring})
            2'b00:   s = LN_IDLE;
            2'b01:   s = LN_RING;
            2'b10:   s = LN_CARR;
            default: s = LN_BOTH;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/modem_tcr_reg.sv
module modem_tcr_reg #(
    parameter int NLINES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_clr,
    input  logic                tcr_we,
    input  logic [1:0]          tcr_be,
    input  logic [2*NLINES-1:0] tcr_wdata,
    output logic [2*NLINES-1:0] tcr_q,
    output logic [NLINES-1:0]   dtr_next,
    output logic                wr_accept
);
    localparam int W = 2 * NLINES;

    logic [W-1:0] tcr_d;

    assign wr_accept = tcr_we && !csr_clr;

    always_comb begin
        tcr_d = tcr_q;
        if (csr_clr) begin
            tcr_d[NLINES-1:0] = '0;
        end else if (tcr_we) begin
            if (tcr_be[0]) tcr_d[NLINES-1:0] = tcr_wdata[NLINES-1:0];
            if (tcr_be[1]) tcr_d[W-1:NLINES] = tcr_wdata[W-1:NLINES];
        end
    end

    assign dtr_next = tcr_d[W-1:NLINES];

    always_ff @(posedge clk) begin
        if (!rst_n) tcr_q <= '0;
        else        tcr_q <= tcr_d;
    end
endmodule

// File: rtl/modem_line_fsm.sv
module modem_line_fsm
    import modem_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mctl_en,
    input  logic auto_en,
    input  logic wr_accept,
    input  logic dtr_old,
    input  logic dtr_new,
    input  logic conn_req,
    input  logic linked,
    output logic ring,
    output logic carr,
    output logic hangup
);
    line_state_t state_q, state_d;
    logic        hang_d;

    // Output decode
    always_comb begin
        unique case (state_q)
            LN_IDLE: begin ring = 1'b0; carr = 1'b0; end
            LN_RING: begin ring = 1'b1; carr = 1'b0; end
            LN_CARR: begin ring = 1'b0; carr = 1'b1; end
            default: begin ring = 1'b1; carr = 1'b1; end
        endcase
    end

    // Next state: write rules, then connect, then disconnect
    always_comb begin
        logic r, c;
        r      = ring;
        c      = carr;
        hang_d = 1'b0;
        if (mctl_en) begin
            if (wr_accept) begin
                if (dtr_new && r) c = 1'b1;       // answer
                if (dtr_new)      r = 1'b0;
                if (auto_en && dtr_old && !dtr_new && linked) begin
                    hang_d = 1'b1;                // hang-up
                    c      = 1'b0;
                end
            end
            if (conn_req) begin
                if (dtr_new) c = 1'b1;            // carrier-on-connect
                else         r = 1'b1;            // ring-on-connect
            end
            if (!linked) c = 1'b0;                // drop
        end
        state_d = pack_state(r, c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            hangup  <= 1'b0;
        end else begin
            state_q <= state_d;
            hangup  <= hang_d;
        end
    end
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl #(
    parameter int NLINES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mctl_en,
    input  logic                auto_en,
    input  logic                csr_clr,
    input  logic                tcr_we,
    input  logic [1:0]          tcr_be,
    input  logic [2*NLINES-1:0] tcr_wdata,
    input  logic [NLINES-1:0]   conn_req,
    input  logic [NLINES-1:0]   connected,
    output logic [2*NLINES-1:0] tcr_q,
    output logic [2*NLINES-1:0] msr_q,
    output logic [NLINES-1:0]   hangup
);
    localparam int W = 2 * NLINES;

    logic [NLINES-1:0] dtr_next;
    logic              wr_accept;
    logic [NLINES-1:0] ring_v, carr_v;

    modem_tcr_reg #(.NLINES(NLINES)) u_tcr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_clr   (csr_clr),
        .tcr_we    (tcr_we),
        .tcr_be    (tcr_be),
        .tcr_wdata (tcr_wdata),
        .tcr_q     (tcr_q),
        .dtr_next  (dtr_next),
        .wr_accept (wr_accept)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        modem_line_fsm u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .mctl_en   (mctl_en),
            .auto_en   (auto_en),
            .wr_accept (wr_accept),
            .dtr_old   (tcr_q[NLINES+i]),
            .dtr_new   (dtr_next[i]),
            .conn_req  (conn_req[i]),
            .linked    (connected[i]),
            .ring      (ring_v[i]),
            .carr      (carr_v[i]),
            .hangup    (hangup[i])
        );
    end

    assign msr_q = {carr_v, ring_v};
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk #(
    parameter int NLINES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mctl_en,
    input logic                auto_en,
    input logic                csr_clr,
    input logic                tcr_we,
    input logic [2*NLINES-1:0] tcr_q,
    input logic [2*NLINES-1:0] msr_q,
    input logic [NLINES-1:0]   connected,
    input logic [NLINES-1:0]   hangup
);
    localparam int W = 2 * NLINES;

    a_r3_clear_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        csr_clr |=> (tcr_q[NLINES-1:0] == '0) && (tcr_q[W-1:NLINES] == $past(tcr_q[W-1:NLINES])));

    a_r6_ring_cleared_by_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mctl_en && tcr_we && !csr_clr) |=> ((msr_q[NLINES-1:0] & tcr_q[W-1:NLINES]) == '0));

    a_r7_hangup_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (hangup != '0) |-> ($past(tcr_we && auto_en && mctl_en && !csr_clr)
                            && ((msr_q[W-1:NLINES] & hangup) == '0)
                            && ((tcr_q[W-1:NLINES] & hangup) == '0)));

    a_r8_no_carrier_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
        mctl_en |=> ((msr_q[W-1:NLINES] & ~$past(connected)) == '0));

    a_r9_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mctl_en |=> (msr_q == $past(msr_q)) && (hangup == '0));
endmodule

bind modem_ctl modem_ctl_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mctl_en   (mctl_en),
    .auto_en   (auto_en),
    .csr_clr   (csr_clr),
    .tcr_we    (tcr_we),
    .tcr_q     (tcr_q),
    .msr_q     (msr_q),
    .connected (connected),
    .hangup    (hangup)
);

// File: tb/modem_ctl_tb.sv
`timescale 1ns/1ps
module modem_ctl_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mctl_en = 1'b0, auto_en = 1'b0, csr_clr = 1'b0, tcr_we = 1'b0;
    logic [1:0]   tcr_be = '0;
    logic [15:0]  tcr_wdata = '0;
    logic [N-1:0] conn_req = '0, connected = '0;
    logic [15:0]  tcr_q, msr_q;
    logic [N-1:0] hangup;

    int checks = 0, fails = 0;
    logic [31:0] seed = 32'h1234_5678;

    // model state
    logic [15:0]  m_tcr = '0;
    logic [N-1:0] m_ring = '0, m_carr = '0, m_hang = '0;

    always #5 clk = ~clk;

    modem_ctl #(.NLINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .mctl_en(mctl_en), .auto_en(auto_en),
        .csr_clr(csr_clr), .tcr_we(tcr_we), .tcr_be(tcr_be), .tcr_wdata(tcr_wdata),
        .conn_req(conn_req), .connected(connected),
        .tcr_q(tcr_q), .msr_q(msr_q), .hangup(hangup)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 R3 tcr_q", tcr_q, m_tcr);
        chk("R4 R5 R6 R9 ring bits", {8'h00, msr_q[7:0]}, {8'h00, m_ring});
        chk("R4 R5 R6 R7 R8 carrier bits", {8'h00, msr_q[15:8]}, {8'h00, m_carr});
        chk("R7 R9 hangup", {8'h00, hangup}, {8'h00, m_hang});
    endtask

    // Apply one cycle of stimulus (called at a negedge) and advance the model
    task automatic apply(input logic mc, input logic au, input logic cl, input logic we,
                         input logic [1:0] be, input logic [15:0] wd,
                         input logic [N-1:0] cr, input logic [N-1:0] cn);
        logic [15:0]  t;
        logic [N-1:0] nd, od, r, c, h;
        mctl_en = mc; auto_en = au; csr_clr = cl; tcr_we = we;
        tcr_be = be; tcr_wdata = wd; conn_req = cr; connected = cn;
        t = m_tcr;
        if (cl) t[7:0] = 8'h00;
        else if (we) begin
            if (be[0]) t[7:0]  = wd[7:0];
            if (be[1]) t[15:8] = wd[15:8];
        end
        od = m_tcr[15:8]; nd = t[15:8];
        r = m_ring; c = m_carr; h = '0;
        if (mc) begin
            if (we && !cl) begin
                c = c | (nd & r);
                r = r & ~nd;
                if (au) begin
                    h = od & ~nd & cn;
                    c = c & ~h;
                end
            end
            c = c | (cr & nd);
            r = r | (cr & ~nd);
            c = c & cn;
        end
        m_tcr = t; m_ring = r; m_carr = c; m_hang = h;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] cn;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tcr_q reset", tcr_q, 16'h0000);
        chk("R1 msr_q reset", msr_q, 16'h0000);
        chk("R1 hangup reset", {8'h00, hangup}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // Directed sweep over every line and both ready values (R5, R6, R7)
        cn = '0;
        for (int i = 0; i < N; i++) begin
            for (int d = 0; d < 2; d++) begin
                logic [15:0] wd;
                wd = 16'h0000;
                wd[8+i] = d[0];
                apply(1, 1, 0, 1, 2'b10, wd, '0, cn);
                @(negedge clk); check_all();
                cn[i] = 1'b1;
                apply(1, 1, 0, 0, 2'b00, '0, N'(1) << i, cn);
                @(negedge clk); check_all();
                // raise ready: rings turn into carrier (R6)
                wd[8+i] = 1'b1;
                apply(1, 1, 0, 1, 2'b10, wd, '0, cn);
                @(negedge clk); check_all();
                // drop ready on a connected line: hang-up (R7)
                apply(1, 1, 0, 1, 2'b10, 16'h0000, '0, cn);
                @(negedge clk); check_all();
                cn[i] = 1'b0;
                apply(1, 1, 0, 0, 2'b00, '0, '0, cn);
                @(negedge clk); check_all();
            end
        end

        // Pseudo-random phases over all enable combinations (R2, R3, R8, R9)
        for (int ph = 0; ph < 8; ph++) begin
            logic mc, au;
            mc = ph[0]; au = ph[1];
            for (int k = 0; k < 700; k++) begin
                logic [31:0] a, b;
                logic [N-1:0] cr, drop;
                seed = nxt(seed); a = seed;
                seed = nxt(seed); b = seed;
                cr   = a[7:0] & a[15:8] & a[23:16];
                drop = b[23:16] & b[31:24] & a[15:8];
                cn   = (cn | cr) & ~m_hang & ~drop;
                apply(mc, au, a[27:24] == 4'h0, a[29:28] == 2'b00, a[31:30], b[15:0], cr, cn);
                @(negedge clk);
                check_all();
            end
        end

        apply(0, 0, 0, 0, 2'b00, '0, '0, cn);
        @(negedge clk);
        check_all();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule